// File: doc/BRIEF.md
# Zero-One-One Serial Pattern Detector

This block watches a one-bit serial stream and flags every place where a zero is followed by two ones. It samples the input once per clock. Two detectors run side by side on the same stream so that a designer can pick whichever timing suits the logic downstream.

The state-based detector moves into a dedicated "found" state once the pattern completes. Its flag comes from a register and rises in the cycle after the final one is sampled. The input-based detector uses one state fewer. Its flag is decoded from the present state together with the live input, so it rises in the very cycle in which the final one is presented.

After a match, both detectors go on searching, so every later occurrence is reported as well. The reset input is asynchronous and active low. Its assertion takes effect at once, and its release is passed through a small synchronizer before the state machines leave reset.

Top module: `seq011_detector`

## Requirements
- R1: While `rst_n` is low, both detect outputs are low and both machines are held idle. After `rst_n` rises, no detection is reported until a fresh zero, one, one has been sampled.
- R2: `hit_moore` is high for exactly the one clock cycle that follows the rising edge at which the final one of a zero, one, one sequence was sampled.
- R3: `hit_mealy` is high during any cycle in which `din` is 1 and the two previously sampled bits were 0 then 1, both taken since reset.
- R4: Any run of zeros before the first one still leads to a detection, as in 0,0,0,1,1.
- R5: A zero that arrives after 0,1 restarts the search from "one zero seen", so 0,1,0,1,1 is detected once, at its end.
- R6: A zero right after a match counts as the start of the next pattern, so the stream 0,1,1,0,1,1 is reported twice.
- R7: A one right after a match returns the machine to idle, so the stream 0,1,1,1,1 is reported only once.
- R8: `hit_moore` is never high in two consecutive cycles.
- R9: Outside reset, `hit_moore` is high in a cycle exactly when `hit_mealy` was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `din` is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | 1 | Serial data bit |
| hit_moore | output | 1 | Registered detection flag, one cycle after the pattern completes |
| hit_mealy | output | 1 | Combinational detection flag, during the cycle of the final one |

## Verification
The assertions assume that `din` is steady around each rising clock edge. They also assume that `rst_n` is released only while `din` holds 1, so the synchronizer window cannot begin a half-seen pattern. The bench changes `din` only on falling edges and keeps it at 1 across every reset and release. Beyond that, the bench streams every 10-bit pattern back to back, then a long random stream. It compares both flags against a two-bit history of the sampled input.

// File: rtl/seq011_pkg.sv
package seq011_pkg;

  // States of the registered-output detector
  typedef enum logic [1:0] {
    MO_IDLE  = 2'd0,
    MO_ZERO  = 2'd1,
    MO_ZONE  = 2'd2,
    MO_FOUND = 2'd3
  } moore_st_t;

  // States of the input-decoded detector
  typedef enum logic [1:0] {
    ME_IDLE = 2'd0,
    ME_ZERO = 2'd1,
    ME_ZONE = 2'd2
  } mealy_st_t;

endpackage

// File: rtl/seq011_rst_sync.sv
module seq011_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/seq011_moore_fsm.sv
module seq011_moore_fsm
  import seq011_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic hit
);

  moore_st_t state_q, state_d;
  logic      hit_q;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MO_IDLE:  state_d = din ? MO_IDLE : MO_ZERO;
      MO_ZERO:  state_d = din ? MO_ZONE : MO_ZERO;
      MO_ZONE:  state_d = din ? MO_FOUND : MO_ZERO;
      MO_FOUND: state_d = din ? MO_IDLE : MO_ZERO;
      default:  state_d = MO_IDLE;
    endcase
  end

  // State and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MO_IDLE;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hit_q   <= (state_d == MO_FOUND);
    end
  end

  assign hit = hit_q;

endmodule

// File: rtl/seq011_mealy_fsm.sv
module seq011_mealy_fsm
  import seq011_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic hit
);

  mealy_st_t state_q, state_d;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ME_IDLE: state_d = din ? ME_IDLE : ME_ZERO;
      ME_ZERO: state_d = din ? ME_ZONE : ME_ZERO;
      ME_ZONE: state_d = din ? ME_IDLE : ME_ZERO;
      default: state_d = ME_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ME_IDLE;
    else        state_q <= state_d;
  end

  // Output decoded from the present state and the live input
  assign hit = (state_q == ME_ZONE) && din;

endmodule

// File: rtl/seq011_detector.sv
module seq011_detector #(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic hit_moore,
  output logic hit_mealy
);

  logic rst_n_int;

  seq011_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  seq011_moore_fsm u_moore (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (din),
    .hit   (hit_moore)
  );

  seq011_mealy_fsm u_mealy (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (din),
    .hit   (hit_mealy)
  );

endmodule

// File: rtl/seq011_detector_checker.sv
module seq011_detector_checker (
  input logic clk,
  input logic rst_n,
  input logic din,
  input logic hit_moore,
  input logic hit_mealy
);

  // R1: both flags are low whenever reset is applied
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!hit_moore && !hit_mealy));

  // R3: the input-decoded flag needs a 1 on the input
  a_r3_mealy_needs_one: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mealy |-> din);

  // R2: the registered flag follows a sampled 1
  a_r2_moore_after_one: assert property (@(posedge clk) disable iff (!rst_n)
    hit_moore |-> $past(din));

  // R8: the registered flag lasts a single cycle
  a_r8_moore_single: assert property (@(posedge clk) disable iff (!rst_n)
    hit_moore |=> !hit_moore);

  // R9: the registered flag trails the input-decoded flag by one cycle
  a_r9_mealy_then_moore: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mealy |=> hit_moore);

  a_r9_moore_from_mealy: assert property (@(posedge clk) disable iff (!rst_n)
    hit_moore |-> $past(hit_mealy));

endmodule

bind seq011_detector seq011_detector_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .din       (din),
  .hit_moore (hit_moore),
  .hit_mealy (hit_mealy)
);

// File: tb/seq011_detector_test.sv
module seq011_detector_test;

  logic clk = 1'b0;
  logic rst_n;
  logic din;
  logic hit_moore, hit_mealy;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  logic [1:0] hist;
  logic       exp_moore;
  int         moore_count;

  always #2 clk = ~clk;

  seq011_detector uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .hit_moore (hit_moore),
    .hit_mealy (hit_mealy)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // Drive one bit and check both flags against the history model
  task automatic step(input logic b, input string tag);
    logic em;
    @(negedge clk);
    din = b;
    #1;
    em = (hist == 2'b01) && b;
    check({tag, " mealy (R3)"}, hit_mealy, em);
    check({tag, " moore (R2)"}, hit_moore, exp_moore);
    if (hit_moore === 1'b1) moore_count++;
    exp_moore = em;
    hist = {hist[0], b};
  endtask

  task automatic do_reset();
    @(negedge clk);
    din   = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R1 moore in reset", hit_moore, 1'b0);
    check("R1 mealy in reset", hit_mealy, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 moore held", hit_moore, 1'b0);
      check("R1 mealy held", hit_mealy, 1'b0);
    end
    rst_n     = 1'b1;
    hist      = 2'b11;
    exp_moore = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, "R1 release");
  endtask

  task automatic run_seq(input logic [15:0] bits, input int len,
                         input int want, input string tag);
    moore_count = 0;
    for (int i = len - 1; i >= 0; i--) step(bits[i], tag);
    step(1'b1, tag);
    step(1'b1, tag);
    n_checks++;
    if (moore_count != want) begin
      n_fail++;
      $display("FAIL %s count: actual %0d expected %0d", tag, moore_count, want);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    din   = 1'b1;
    do_reset();

    // Directed corner cases
    run_seq(16'b100011, 6, 1, "R4");
    run_seq(16'b01011, 5, 1, "R5");
    run_seq(16'b011011, 6, 2, "R6");
    run_seq(16'b01111, 5, 1, "R7");
    run_seq(16'b0110, 4, 1, "R8");

    // Every 10-bit pattern back to back
    for (int p = 0; p < 1024; p++) begin
      logic [9:0] v;
      v = p[9:0];
      for (int i = 9; i >= 0; i--) step(v[i], "sweep R9");
    end

    // Reset in mid-stream, then check R1 behaviour once more
    step(1'b0, "R1 pre");
    step(1'b1, "R1 pre");
    do_reset();
    run_seq(16'b1, 1, 0, "R1 no stale");

    // Long random stream
    for (int i = 0; i < 20000; i++) step(1'($urandom_range(0, 1)), "random R2");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule